// File: doc/BRIEF.md
# Endian-Aware Sub-word Lane Unit

This unit sits between a 32-bit word held in a cache line and the processor's load/store path. For a load it picks a byte or halfword out of the stored word and returns it zero-extended; for a store it folds a byte or halfword into the existing word and leaves the other lanes alone. A full-word access passes the word straight through on a load and replaces it on a store.

Which lane is used comes from the two low address bits combined with a big-endian flag. The flag is XORed into the address bits to give the lane. When alignment checking is on, misaligned halfword and word accesses are refused with a fault. A store that completes reports which half of the eight-word line it touched, so the surrounding cache can track dirtiness at half-line granularity.

Each request presented with `req_valid` is answered by a registered response one clock later.

Top module: `lane_merge_unit`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_word`, `rsp_fault`, `dirty_first` and `dirty_last` are all zero.
- R2: `rsp_valid` is high in the cycle after a clock edge at which `req_valid` was high, and low otherwise; all response fields belong to that request.
- R3: For a halfword access (`req_size` = 2'b01) the lane starts at bit ((big*2) XOR (addr AND 2)) * 8, so with little-endian, address bit 1 = 0 selects bits 15:0; with big-endian it selects bits 31:16.
- R4: For a byte access (`req_size` = 2'b00) the lane starts at bit ((big*3) XOR addr[1:0]) * 8, so little-endian address 0 selects bits 7:0 and big-endian address 0 selects bits 31:24.
- R5: A sub-word load returns the selected lane in the low bits of `rsp_word` with every higher bit zero.
- R6: A sub-word store returns `old_word` with only the selected lane replaced by the low 8 or 16 bits of `wr_data`.
- R7: `req_size` 2'b10 and 2'b11 are word accesses: a load returns `old_word` and a store returns `wr_data`, whatever the address bits are.
- R8: With `align_chk` high, a word access with addr[1:0] != 0 or a halfword access with addr[0] = 1 raises `rsp_fault`. Byte accesses never fault, and nothing faults while `align_chk` is low.
- R9: A faulting access returns `rsp_word` equal to the `old_word` of that request and sets neither dirty flag.
- R10: A store that does not fault sets `dirty_first` when `word_idx` is below half the line length (0 to 3 for eight words) and `dirty_last` otherwise. Loads set neither flag, and the two flags are never high together.
- R11: In a cycle after no request, `rsp_fault`, `dirty_first` and `dirty_last` are low and `rsp_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store merge, 0 = load extract |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| addr_lo | input | 2 | Low two bits of the byte address |
| big_endian | input | 1 | Lane order is big-endian when high |
| align_chk | input | 1 | Enables alignment faults |
| old_word | input | 32 | Word currently held in the line |
| wr_data | input | 32 | Store data, right-justified for sub-word sizes |
| word_idx | input | 3 | Word position within the line |
| rsp_valid | output | 1 | Response present |
| rsp_word | output | 32 | Extracted load value or merged store word |
| rsp_fault | output | 1 | Alignment fault for the answered request |
| dirty_first | output | 1 | Store marked the first half of the line dirty |
| dirty_last | output | 1 | Store marked the second half of the line dirty |

## Verification
On every cycle the assertions check the response timing, that the two dirty flags never rise together, that faults suppress dirtying and return the old word, that byte accesses and disabled checking never fault, and that loads and idle cycles leave the dirty flags low. Lane placement itself, zero extension, the preservation of untouched lanes in a merge and the exact half-line boundary depend on data values, so only the bench's sweep over every size, address, endianness, check setting and word index can show them.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD3 = 2'b11
  } xfer_size_e;

  // Bit offset of a halfword lane: endian flag folded into address bit 1.
  function automatic logic [4:0] half_shift(input logic big, input logic [1:0] a);
    logic [1:0] k;
    k = {big, 1'b0} ^ {a[1], 1'b0};
    return {k, 3'b000};
  endfunction

  // Bit offset of a byte lane: endian flag folded into both address bits.
  function automatic logic [4:0] byte_shift(input logic big, input logic [1:0] a);
    logic [1:0] k;
    k = {big, big} ^ a;
    return {k, 3'b000};
  endfunction

  function automatic logic misaligned(input xfer_size_e sz, input logic [1:0] a,
                                      input logic chk);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return chk & a[0];
      default: return chk & (|a);
    endcase
  endfunction
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] addr,
  input  logic       chk_en,
  output logic       fault
);
  always_comb fault = misaligned(xfer_size_e'(size), addr, chk_en);
endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        addr,
  input  logic              big,
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] merge_word
);
  localparam logic [WORD_W-1:0] BYTE_MASK = {{(WORD_W-8){1'b0}}, 8'hFF};
  localparam logic [WORD_W-1:0] HALF_MASK = {{(WORD_W-16){1'b0}}, 16'hFFFF};

  logic [4:0]        sh;
  logic [WORD_W-1:0] mask;

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: begin sh = byte_shift(big, addr); mask = BYTE_MASK; end
      SZ_HALF: begin sh = half_shift(big, addr); mask = HALF_MASK; end
      default: begin sh = 5'd0;                  mask = '1;        end
    endcase
    load_word  = (old_word >> sh) & mask;
    merge_word = (old_word & ~(mask << sh)) | ((wr_data & mask) << sh);
  end
endmodule

// File: rtl/line_half_dirty.sv
module line_half_dirty #(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic             mark_en,
  input  logic [IDX_W-1:0] idx,
  output logic             first_half,
  output logic             last_half
);
  localparam int HALF_WORDS = LINE_WORDS / 2;

  generate
    if (HALF_WORDS == 0) begin : g_single
      logic unused_idx;
      assign unused_idx = ^idx;
      assign first_half = mark_en;
      assign last_half  = 1'b0;
    end else begin : g_split
      logic low_side;
      assign low_side   = int'(idx) < HALF_WORDS;
      assign first_half = mark_en & low_side;
      assign last_half  = mark_en & ~low_side;
    end
  endgenerate
endmodule

// File: rtl/lane_merge_unit.sv
module lane_merge_unit
  import lane_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [1:0]        addr_lo,
  input  logic              big_endian,
  input  logic              align_chk,
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  word_idx,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_fault,
  output logic              dirty_first,
  output logic              dirty_last
);
  logic              align_fault_w;
  logic [WORD_W-1:0] load_word_w;
  logic [WORD_W-1:0] merge_word_w;
  logic              store_ok_w;
  logic              mark_first_w;
  logic              mark_last_w;
  logic [WORD_W-1:0] next_word_w;

  lane_align_check u_align (
    .size   (req_size),
    .addr   (addr_lo),
    .chk_en (align_chk),
    .fault  (align_fault_w)
  );

  lane_shuffle u_shuffle (
    .size       (req_size),
    .addr       (addr_lo),
    .big        (big_endian),
    .old_word   (old_word),
    .wr_data    (wr_data),
    .load_word  (load_word_w),
    .merge_word (merge_word_w)
  );

  assign store_ok_w = req_valid & req_store & ~align_fault_w;

  line_half_dirty #(.LINE_WORDS(LINE_WORDS)) u_dirty (
    .mark_en    (store_ok_w),
    .idx        (word_idx),
    .first_half (mark_first_w),
    .last_half  (mark_last_w)
  );

  always_comb begin
    if (align_fault_w)  next_word_w = old_word;
    else if (req_store) next_word_w = merge_word_w;
    else                next_word_w = load_word_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_word    <= '0;
      rsp_fault   <= 1'b0;
      dirty_first <= 1'b0;
      dirty_last  <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid & align_fault_w;
      dirty_first <= mark_first_w;
      dirty_last  <= mark_last_w;
      if (req_valid) rsp_word <= next_word_w;
    end
  end
endmodule

// File: rtl/lane_merge_unit_chk.sv
module lane_merge_unit_chk
  import lane_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic              align_chk,
  input logic [WORD_W-1:0] old_word,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_word,
  input logic              rsp_fault,
  input logic              dirty_first,
  input logic              dirty_last,
  input logic              align_fault_w
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_dirty_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dirty_first, dirty_last}));

  assert_load_not_dirty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> (!dirty_first && !dirty_last));

  assert_fault_not_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (!dirty_first && !dirty_last));

  assert_fault_keeps_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && align_fault_w) |=> (rsp_fault && rsp_word == $past(old_word)));

  assert_byte_never_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |=> !rsp_fault);

  assert_unchecked_never_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !align_chk) |=> !rsp_fault);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_fault && !dirty_first && !dirty_last && $stable(rsp_word)));
endmodule

bind lane_merge_unit lane_merge_unit_chk u_lane_chk (.*);

// File: tb/test_lane_merge_unit.sv
`timescale 1ns/1ps
module test_lane_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [1:0]  addr_lo = 2'b00;
  logic        big_endian = 1'b0;
  logic        align_chk = 1'b0;
  logic [31:0] old_word = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  word_idx = '0;
  logic        rsp_valid;
  logic [31:0] rsp_word;
  logic        rsp_fault;
  logic        dirty_first;
  logic        dirty_last;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_merge_unit #(.LINE_WORDS(8)) i_lane_merge_unit (
    .clk, .rst_n, .req_valid, .req_store, .req_size, .addr_lo, .big_endian,
    .align_chk, .old_word, .wr_data, .word_idx, .rsp_valid, .rsp_word,
    .rsp_fault, .dirty_first, .dirty_last
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: lane picked by numbering byte positions, not by shift arithmetic.
  task automatic model(input bit st, input bit [1:0] sz, input bit [1:0] a,
                       input bit big, input bit chk, input bit [31:0] old,
                       input bit [31:0] wd, input int idx,
                       output bit [31:0] w, output bit f, output bit df, output bit dl);
    int lane;
    f = chk && ((sz == 2'd1 && a[0]) || (sz[1] && a != 2'd0));
    w = old;
    if (sz == 2'd0) begin
      lane = big ? 3 - int'(a) : int'(a);
      if (st) w[8*lane +: 8] = wd[7:0];
      else    w = {24'h0, old[8*lane +: 8]};
    end else if (sz == 2'd1) begin
      lane = big ? (a[1] ? 0 : 1) : (a[1] ? 1 : 0);
      if (st) w[16*lane +: 16] = wd[15:0];
      else    w = {16'h0, old[16*lane +: 16]};
    end else begin
      w = st ? wd : old;
    end
    if (f) w = old;
    df = st && !f && idx < 4;
    dl = st && !f && idx >= 4;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] ew;
    bit ef, edf, edl;
    string wtag;
    int seq = 0;

    #12;
    // R1: reset state
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 rsp_word", rsp_word, 32'd0);
    check("R1 flags", {29'd0, rsp_fault, dirty_first, dirty_last}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++)
          for (int big = 0; big < 2; big++)
            for (int chk = 0; chk < 2; chk++)
              for (int idx = 0; idx < 8; idx++) begin
                @(negedge clk);
                seq++;
                req_valid  = 1'b1;
                req_store  = st[0];
                req_size   = sz[1:0];
                addr_lo    = a[1:0];
                big_endian = big[0];
                align_chk  = chk[0];
                word_idx   = idx[2:0];
                old_word   = 32'hA1B2C3D4 ^ (32'h01030507 * seq);
                wr_data    = 32'h5E6F7081 + (32'h11223344 * seq);
                model(st[0], sz[1:0], a[1:0], big[0], chk[0], old_word, wr_data, idx,
                      ew, ef, edf, edl);
                @(posedge clk);
                #1;
                if (ef)            wtag = "R9 word";
                else if (sz[1])    wtag = "R7 word";
                else if (st != 0)  wtag = "R6 merge";
                else if (sz == 0)  wtag = "R4/R5 byte load";
                else               wtag = "R3/R5 half load";
                check("R2 valid", {31'd0, rsp_valid}, 32'd1);
                check(wtag, rsp_word, ew);
                check("R8 fault", {31'd0, rsp_fault}, {31'd0, ef});
                check("R10 dirty", {30'd0, dirty_first, dirty_last}, {30'd0, edf, edl});
                // R11: an idle cycle every so often
                if (seq % 7 == 0) begin
                  @(negedge clk);
                  req_valid = 1'b0;
                  old_word  = ~old_word;
                  @(posedge clk);
                  #1;
                  check("R11 valid", {31'd0, rsp_valid}, 32'd0);
                  check("R11 word held", rsp_word, ew);
                  check("R11 flags", {29'd0, rsp_fault, dirty_first, dirty_last}, 32'd0);
                end
              end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule